// File: doc/BRIEF.md
# SYSREF Phase Statistics Monitor

This block gathers statistics on where the rising edge of SYSREF lands relative to the device clock, so that a phase tolerance window can be chosen during characterisation. The capture aligner upstream reports each rising SYSREF edge as a one-cycle valid with a 2-bit phase code. It also reports which of two reference rising clock edges was used for alignment. The monitor keeps one sticky flag per phase and saturating 8-bit occurrence counters per phase and per alignment edge. Firmware reads all of these from plain output ports.

Monitoring is gated by an enable input that is low after reset. A write-one clear strobe zeroes only the statistics, and leaves the status pipeline and everything else untouched. Events pass through a two-stage status pipeline before they are counted. For that reason the intended procedure is to enable monitoring, let a repeating SYSREF run until the pipeline has flushed, and only then clear. Recording is edge-by-edge with no dependence on spacing, so gapped pulse trains accumulate correctly. An alarm output flags any observed phase outside a programmable expected-phase mask.

Top module: `sysref_phase_stats`

## Requirements
- R1: After reset all sticky flags and all counters read zero and the alarm is low.
- R2: While the monitor enable is low at the update point, arriving events change no flag and no counter.
- R3: Phase code n (0..3) sets sticky flag bit n, and that bit stays set until a statistics clear.
- R4: Each phase has an 8-bit occurrence counter at bits [8n+7:8n] of the phase counter port, incremented per counted event of code n, holding at 255 instead of wrapping.
- R5: Alignment-edge indication A increments the counter at bits [7:0] of the alignment counter port and indication B the counter at bits [15:8], both 8-bit and saturating at 255.
- R6: A clear strobe zeroes all flags and counters on the next edge, whether or not monitoring is enabled.
- R7: A clear in the same cycle as an event reaching the update point wins, and that event is discarded. Events still in earlier pipeline stages are not removed by the clear.
- R8: An event presented before rising edge k is reflected on the outputs after edge k+2, through a 2-stage pipeline. An event captured while disabled is still counted if the enable is high when it reaches the update point.
- R9: The alarm is high exactly when the enable is high and some sticky flag n is set whose expected-mask bit n is 0.
- R10: Events separated by idle gaps of arbitrary length accumulate into the same counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| monEnable | input | 1 | Statistics monitoring enable |
| statClear | input | 1 | Write-one statistics clear strobe |
| expectMask | input | 4 | Bit n set means phase code n is expected |
| phaseValid | input | 1 | Rising SYSREF edge observed this cycle |
| phaseCode | input | 2 | Phase of the observed edge, 0..3 |
| alignEdgeA | input | 1 | Alignment was made to reference edge A |
| alignEdgeB | input | 1 | Alignment was made to reference edge B |
| stickyFlags | output | 4 | Per-phase sticky observation flags |
| phaseCnt | output | 32 | Four 8-bit phase counters, phase n at [8n+7:8n] |
| alignCnt | output | 16 | Edge A count at [7:0], edge B count at [15:8] |
| alarm | output | 1 | Unexpected phase observed while enabled |

## Verification
The assertions assume that every input holds at zero while reset is active. They also assume that phaseCode carries a meaningful value whenever phaseValid is high. The stimulus changes inputs only on falling clock edges. It keeps all inputs idle during reset and always drives a legal code alongside a valid. The corner cases stress timing: a clear that collides with an event at the update point, a clear that overtakes an event still in flight, an enable that rises while a stale event is in the pipeline, and long back-to-back runs that drive counters into saturation.

// File: rtl/sysref_stats_pkg.sv
package sysref_stats_pkg;
  localparam int NUM_PHASES   = 4;
  localparam int PHASE_CODE_W = $clog2(NUM_PHASES);
  localparam int NUM_ALIGN    = 2;

  // Strobes handed from control to datapath once per cycle
  typedef struct packed {
    logic                    clearAll;
    logic                    phaseHit;
    logic [PHASE_CODE_W-1:0] phaseSel;
    logic [NUM_ALIGN-1:0]    alignHit;
  } statStrobe_t;
endpackage

// File: rtl/sysref_sat_counter.sv
module sysref_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAX_VAL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      q <= '0;
    else if (clr)                    q <= '0;
    else if (inc && q != MAX_VAL)    q <= q + W'(1);
  end

  // R4 / R5: a full counter never wraps
  a_r4_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && q == MAX_VAL) |=> q == MAX_VAL);

  // R4 / R5: each accepted increment below the limit adds exactly one
  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && q != MAX_VAL) |=> q == $past(q) + W'(1));
endmodule

// File: rtl/sysref_stats_ctrl.sv
module sysref_stats_ctrl
  import sysref_stats_pkg::*;
#(
  parameter int PIPE_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    monEnable,
  input  logic                    statClear,
  input  logic                    phaseValid,
  input  logic [PHASE_CODE_W-1:0] phaseCode,
  input  logic                    alignEdgeA,
  input  logic                    alignEdgeB,
  output statStrobe_t             strobe
);
  localparam int LAST = PIPE_DEPTH - 1;

  typedef struct packed {
    logic                    vld;
    logic [PHASE_CODE_W-1:0] code;
    logic [NUM_ALIGN-1:0]    align;
  } pipeItem_t;

  pipeItem_t stage [PIPE_DEPTH];

  // Status pipeline runs freely; it is not touched by enable or clear
  for (genvar i = 0; i < PIPE_DEPTH; i++) begin : gStage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[i] <= '0;
      end else begin
        if (i == 0) stage[i] <= {phaseValid, phaseCode, alignEdgeB, alignEdgeA};
        else        stage[i] <= stage[(i == 0) ? 0 : i - 1];
      end
    end
  end

  logic updateOk;

  always_comb begin
    updateOk        = monEnable && !statClear;   // clear wins over any event
    strobe.clearAll = statClear;
    strobe.phaseHit = updateOk && stage[LAST].vld;
    strobe.phaseSel = stage[LAST].code;
    strobe.alignHit = updateOk ? stage[LAST].align : '0;
  end
endmodule

// File: rtl/sysref_stats_dp.sv
module sysref_stats_dp
  import sysref_stats_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  statStrobe_t                     strobe,
  input  logic                            monEnable,
  input  logic [NUM_PHASES-1:0]           expectMask,
  output logic [NUM_PHASES-1:0]           stickyFlags,
  output logic [NUM_PHASES*CNT_W-1:0]     phaseCnt,
  output logic [NUM_ALIGN*CNT_W-1:0]      alignCnt,
  output logic                            alarm
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               stickyFlags <= '0;
    else if (strobe.clearAll) stickyFlags <= '0;
    else if (strobe.phaseHit) stickyFlags[strobe.phaseSel] <= 1'b1;
  end

  for (genvar p = 0; p < NUM_PHASES; p++) begin : gPhase
    logic phInc;
    assign phInc = strobe.phaseHit && (strobe.phaseSel == PHASE_CODE_W'(p));

    sysref_sat_counter #(.W(CNT_W)) uPhCnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (strobe.clearAll),
      .inc   (phInc),
      .q     (phaseCnt[p*CNT_W +: CNT_W])
    );

    // R3: a flag once set survives until a clear
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe.clearAll && stickyFlags[p]) |=> stickyFlags[p]);
  end

  for (genvar a = 0; a < NUM_ALIGN; a++) begin : gAlign
    sysref_sat_counter #(.W(CNT_W)) uAlCnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (strobe.clearAll),
      .inc   (strobe.alignHit[a]),
      .q     (alignCnt[a*CNT_W +: CNT_W])
    );
  end

  assign alarm = monEnable && |(stickyFlags & ~expectMask);

  // R6: a clear leaves every statistic at zero
  a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clearAll |=> (stickyFlags == '0 && phaseCnt == '0 && alignCnt == '0));
endmodule

// File: rtl/sysref_phase_stats.sv
module sysref_phase_stats
  import sysref_stats_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int PIPE_DEPTH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        monEnable,
  input  logic                        statClear,
  input  logic [NUM_PHASES-1:0]       expectMask,
  input  logic                        phaseValid,
  input  logic [PHASE_CODE_W-1:0]     phaseCode,
  input  logic                        alignEdgeA,
  input  logic                        alignEdgeB,
  output logic [NUM_PHASES-1:0]       stickyFlags,
  output logic [NUM_PHASES*CNT_W-1:0] phaseCnt,
  output logic [NUM_ALIGN*CNT_W-1:0]  alignCnt,
  output logic                        alarm
);
  statStrobe_t strobe;

  sysref_stats_ctrl #(.PIPE_DEPTH(PIPE_DEPTH)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .monEnable  (monEnable),
    .statClear  (statClear),
    .phaseValid (phaseValid),
    .phaseCode  (phaseCode),
    .alignEdgeA (alignEdgeA),
    .alignEdgeB (alignEdgeB),
    .strobe     (strobe)
  );

  sysref_stats_dp #(.CNT_W(CNT_W)) uDp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .monEnable   (monEnable),
    .expectMask  (expectMask),
    .stickyFlags (stickyFlags),
    .phaseCnt    (phaseCnt),
    .alignCnt    (alignCnt),
    .alarm       (alarm)
  );

  // R2: with monitoring off and no clear, the statistics do not move
  a_r2_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!monEnable && !statClear) |=>
      ($stable(stickyFlags) && $stable(phaseCnt) && $stable(alignCnt)));
endmodule

// File: tb/tb_sysref_phase_stats.sv
`timescale 1ns/1ps
module tb_sysref_phase_stats;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        monEnable = 1'b0;
  logic        statClear = 1'b0;
  logic [3:0]  expectMask = 4'b0011;
  logic        phaseValid = 1'b0;
  logic [1:0]  phaseCode = 2'd0;
  logic        alignEdgeA = 1'b0;
  logic        alignEdgeB = 1'b0;
  logic [3:0]  stickyFlags;
  logic [31:0] phaseCnt;
  logic [15:0] alignCnt;
  logic        alarm;

  always #2.5 clk = ~clk;

  sysref_phase_stats dut (
    .clk(clk), .rst_n(rst_n), .monEnable(monEnable), .statClear(statClear),
    .expectMask(expectMask), .phaseValid(phaseValid), .phaseCode(phaseCode),
    .alignEdgeA(alignEdgeA), .alignEdgeB(alignEdgeB),
    .stickyFlags(stickyFlags), .phaseCnt(phaseCnt), .alignCnt(alignCnt), .alarm(alarm)
  );

  typedef struct {
    string      req;
    logic [3:0] flags;
    logic       alm;
    int         ph [4];
    int         al [2];
  } expItem_t;

  expItem_t   sbq [$];
  int         nTests = 0;
  int         nFails = 0;
  logic [3:0] mFlags = '0;
  int         mPh [4] = '{0, 0, 0, 0};
  int         mAl [2] = '{0, 0};

  function automatic int satAdd(int v, int n);
    return (v + n > 255) ? 255 : v + n;
  endfunction

  task automatic checkVal(string req, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      expItem_t e;
      wait (sbq.size() != 0);
      e = sbq.pop_front();
      checkVal(e.req, "flags", int'(stickyFlags), int'(e.flags));
      checkVal(e.req, "alarm", int'(alarm), int'(e.alm));
      for (int p = 0; p < 4; p++)
        checkVal(e.req, $sformatf("phaseCnt[%0d]", p), int'(phaseCnt[p*8 +: 8]), e.ph[p]);
      for (int a = 0; a < 2; a++)
        checkVal(e.req, $sformatf("alignCnt[%0d]", a), int'(alignCnt[a*8 +: 8]), e.al[a]);
    end
  end

  // Driver side: push the expected state and wait until it is consumed
  task automatic snap(string req);
    expItem_t e;
    e.req   = req;
    e.flags = mFlags;
    e.alm   = monEnable && |(mFlags & ~expectMask);
    e.ph    = mPh;
    e.al    = mAl;
    sbq.push_back(e);
    wait (sbq.size() == 0);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // One-cycle event from a falling edge; returns once it has left the pipeline
  task automatic ev(logic v, logic [1:0] code, logic a, logic b, bit counted);
    phaseValid = v; phaseCode = code; alignEdgeA = a; alignEdgeB = b;
    @(negedge clk);
    phaseValid = 1'b0; alignEdgeA = 1'b0; alignEdgeB = 1'b0;
    idle(2);
    if (counted) begin
      if (v) begin mFlags[code] = 1'b1; mPh[code] = satAdd(mPh[code], 1); end
      if (a) mAl[0] = satAdd(mAl[0], 1);
      if (b) mAl[1] = satAdd(mAl[1], 1);
    end
  endtask

  task automatic clearModel();
    mFlags = '0; mPh = '{0, 0, 0, 0}; mAl = '{0, 0};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(1);
    snap("R1");

    // R2: disabled monitor ignores all kinds of events
    for (int c = 0; c < 4; c++) ev(1'b1, 2'(c), 1'b1, 1'b1, 1'b0);
    snap("R2");

    // R8: latency through the 2-stage pipeline
    monEnable = 1'b1;
    idle(3);
    phaseValid = 1'b1; phaseCode = 2'd1;
    @(negedge clk);                 // after edge k
    phaseValid = 1'b0;
    @(negedge clk);                 // after edge k+1: not yet visible
    snap("R8");
    @(negedge clk);                 // after edge k+2: visible
    mFlags[1] = 1'b1; mPh[1] = 1;
    snap("R8");

    // R3 / R9: unexpected phase raises the alarm, flag is sticky
    ev(1'b1, 2'd3, 1'b0, 1'b0, 1'b1);
    snap("R9");
    idle(10);
    snap("R3");
    expectMask = 4'b1111;
    idle(1);
    snap("R9");
    expectMask = 4'b0011;
    monEnable = 1'b0;
    idle(1);
    snap("R9");
    monEnable = 1'b1;

    // R10 / R5: gapped train with alignment indications
    for (int g = 0; g < 6; g++) begin
      ev(1'b1, (g % 2 == 0) ? 2'd0 : 2'd2, (g % 3 == 0), (g % 3 != 0), 1'b1);
      idle(5 + g * 13);
    end
    snap("R10");
    snap("R5");

    // R4: back-to-back run saturates a phase counter
    phaseValid = 1'b1; phaseCode = 2'd2;
    repeat (300) @(negedge clk);
    phaseValid = 1'b0;
    idle(2);
    mPh[2] = satAdd(mPh[2], 300); mFlags[2] = 1'b1;
    snap("R4");

    // R5: alignment counter B saturates, A keeps counting
    alignEdgeB = 1'b1;
    repeat (270) @(negedge clk);
    alignEdgeB = 1'b0;
    alignEdgeA = 1'b1;
    repeat (7) @(negedge clk);
    alignEdgeA = 1'b0;
    idle(2);
    mAl[1] = 255; mAl[0] = satAdd(mAl[0], 7);
    snap("R5");

    // R6: clear works with monitoring disabled
    monEnable = 1'b0;
    statClear = 1'b1;
    @(negedge clk);
    statClear = 1'b0;
    clearModel();
    snap("R6");
    monEnable = 1'b1;

    // R7: clear colliding with an event at the update point discards it
    phaseValid = 1'b1; phaseCode = 2'd3; alignEdgeA = 1'b1;
    @(negedge clk);
    phaseValid = 1'b0; alignEdgeA = 1'b0;
    @(negedge clk);
    statClear = 1'b1;               // sampled on the edge the event is counted
    @(negedge clk);
    statClear = 1'b0;
    idle(2);
    snap("R7");

    // R7: clear does not remove an event still in an earlier stage
    phaseValid = 1'b1; phaseCode = 2'd0; alignEdgeB = 1'b1;
    @(negedge clk);
    phaseValid = 1'b0; alignEdgeB = 1'b0;
    statClear = 1'b1;               // sampled one edge before the event lands
    @(negedge clk);
    statClear = 1'b0;
    @(negedge clk);
    mFlags[0] = 1'b1; mPh[0] = 1; mAl[1] = 1;
    snap("R7");

    // R8: stale event captured while disabled is counted once enabled
    monEnable = 1'b0;
    phaseValid = 1'b1; phaseCode = 2'd2;
    @(negedge clk);
    phaseValid = 1'b0;
    monEnable = 1'b1;               // high before the event reaches update
    idle(2);
    mFlags[2] = 1'b1; mPh[2] = 1;
    snap("R8");

    idle(3);
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule